// File: doc/BRIEF.md
# Processor Control Flag Register with Set/Clear Commands

This block is the control and status register that a host uses to steer a small processor core. A host write to the status slot is a command word, not data. Every controllable flag has its own pair of request bits, one to raise it and one to drop it. The flags are halt, single-step, interrupt-on-break, eight general signal flags and the host interrupt line. Raising one flag therefore never disturbs another. The break flag is raised only by a one-cycle pulse from the core, and the host can only clear it.

The block keeps the flags and drives the interrupt line to the host. When a halt request really moves the core from running to halted, it sends the core a one-cycle halt pulse and holds the halted level. It also stores four plain data words (local address, external address, read length, write length) that a transfer engine uses. Reads are registered. They return one of those words, or a status word that merges the stored flags with the busy and full levels supplied by the transfer engine.

Top module: `csr_setclr_ctrl`

## Requirements
- R1: Reset gives a status read of 0x00000001 (only halt set), with `irq_o`, `halt_req_o` and `brk` all 0 and `halted_o` 1.
- R2: In a status write (sel 4), a flag whose set bit alone is 1 becomes 1, and one whose clear bit alone is 1 becomes 0. Command bits: clear/set halt 0/1, clear/set interrupt 3/4, clear/set single-step 5/6, clear/set interrupt-on-break 7/8, and for signal k clear 9+2k and set 10+2k.
- R3: A flag whose set and clear bits are both 1, or both 0, in a status write keeps its value.
- R4: The break flag (status bit 1) rises only after a `brk_pulse_i` cycle. Command bit 2 clears it, and no command bit sets it.
- R5: When `brk_pulse_i` and a break-clear command arrive in the same cycle, break ends up 1.
- R6: A set-halt command sent while not halted drives `halt_req_o` high for exactly the one cycle after the write. The same command sent while already halted gives no pulse.
- R7: The interrupt pair drives `irq_o`, which changes in the cycle after the write. No status bit reflects it.
- R8: Status layout: halt 0, break 1, `dma_busy_i` 2, `dma_full_i` 3, bit 4 zero, single-step 5, interrupt-on-break 6, signals 0..7 at bits 7..14, upper bits zero.
- R9: Sel 0..3 read back the last word written to that slot. Writes there leave the flags untouched. Sel 5..7 read as zero.
- R10: `rdata_o` shows the selected value one cycle after a cycle with `rd_en` high and holds while `rd_en` is low. A read in the same cycle as a write returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 3 | Register slot select |
| wdata | input | 32 | Write data or command word |
| rdata_o | output | 32 | Registered read data |
| dma_busy_i | input | 1 | Transfer engine busy level |
| dma_full_i | input | 1 | Transfer engine full level |
| brk_pulse_i | input | 1 | One-cycle break event from the core |
| irq_o | output | 1 | Interrupt line to the host |
| halt_req_o | output | 1 | One-cycle halt pulse to the core |
| halted_o | output | 1 | Halt flag level |

## Verification
A wrong stored flag shows up in the next status read, one cycle after the read strobe. The interrupt line shows its own fault in the cycle right after the command write. A faulty halt edge detector shows up the cycle after the write, either as a missing pulse, a pulse while already halted, or a pulse longer than one cycle. Mis-decoded command positions or swapped status positions appear as a wrong bit in the read word. The bench therefore sweeps single, paired and empty commands across several flags and reads the status word after each one.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // pair indices inside the set/clear vectors
  localparam int PI_HALT  = 0;
  localparam int PI_IRQ   = 1;
  localparam int PI_SSTEP = 2;
  localparam int PI_IBRK  = 3;
  localparam int PI_SIG0  = 4;

  // break has only a clear request
  localparam int CMD_BRK_CLR = 2;

  // status word bit positions
  localparam int ST_HALT  = 0;
  localparam int ST_BRK   = 1;
  localparam int ST_BUSY  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_SSTEP = 5;
  localparam int ST_IBRK  = 6;
  localparam int ST_SIG0  = 7;

  // register slots
  localparam int SLOT_STAT = 4;

  function automatic int clr_pos(input int idx);
    case (idx)
      PI_HALT:  clr_pos = 0;
      PI_IRQ:   clr_pos = 3;
      PI_SSTEP: clr_pos = 5;
      PI_IBRK:  clr_pos = 7;
      default:  clr_pos = 9 + 2 * (idx - PI_SIG0);
    endcase
  endfunction

  function automatic int set_pos(input int idx);
    set_pos = clr_pos(idx) + 1;
  endfunction
endpackage

// File: rtl/csr_cmd_decode.sv
module csr_cmd_decode
  import csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NPAIR  = 12
) (
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] cmd,
  output logic [NPAIR-1:0]  set_o,
  output logic [NPAIR-1:0]  clr_o,
  output logic              brk_clr_o
);
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam int SP = set_pos(g);
    localparam int CP = clr_pos(g);
    logic want_set, want_clr;
    assign want_set = stat_wr & cmd[SP];
    assign want_clr = stat_wr & cmd[CP];
    // a request that names both directions cancels out
    assign set_o[g] = want_set & ~want_clr;
    assign clr_o[g] = want_clr & ~want_set;
  end

  assign brk_clr_o = stat_wr & cmd[CMD_BRK_CLR];
endmodule

// File: rtl/csr_flag_bank.sv
module csr_flag_bank
  import csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSIG   = 8,
  localparam int NPAIR = PI_SIG0 + NSIG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPAIR-1:0]  set_v,
  input  logic [NPAIR-1:0]  clr_v,
  input  logic              brk_clr,
  input  logic              brk_pulse,
  input  logic              dma_busy,
  input  logic              dma_full,
  output logic              irq_o,
  output logic              halt_req_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] stat_o
);
  logic            halt_q, brk_q, sstep_q, ibrk_q, irq_q, hreq_q;
  logic [NSIG-1:0] sig_q;

  function automatic logic pair_next(input logic cur, input logic s, input logic c);
    pair_next = s ? 1'b1 : (c ? 1'b0 : cur);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b1;
      brk_q   <= 1'b0;
      sstep_q <= 1'b0;
      ibrk_q  <= 1'b0;
      irq_q   <= 1'b0;
      hreq_q  <= 1'b0;
    end else begin
      halt_q  <= pair_next(halt_q,  set_v[PI_HALT],  clr_v[PI_HALT]);
      sstep_q <= pair_next(sstep_q, set_v[PI_SSTEP], clr_v[PI_SSTEP]);
      ibrk_q  <= pair_next(ibrk_q,  set_v[PI_IBRK],  clr_v[PI_IBRK]);
      irq_q   <= pair_next(irq_q,   set_v[PI_IRQ],   clr_v[PI_IRQ]);
      // the core event outranks a host clear
      brk_q   <= brk_pulse ? 1'b1 : (brk_clr ? 1'b0 : brk_q);
      // only a running-to-halted transition pulses the core
      hreq_q  <= set_v[PI_HALT] & ~halt_q;
    end
  end

  for (genvar k = 0; k < NSIG; k++) begin : g_sig
    always_ff @(posedge clk) begin
      if (rst) sig_q[k] <= 1'b0;
      else     sig_q[k] <= pair_next(sig_q[k], set_v[PI_SIG0+k], clr_v[PI_SIG0+k]);
    end
  end

  always_comb begin
    stat_o                     = '0;
    stat_o[ST_HALT]            = halt_q;
    stat_o[ST_BRK]             = brk_q;
    stat_o[ST_BUSY]            = dma_busy;
    stat_o[ST_FULL]            = dma_full;
    stat_o[ST_SSTEP]           = sstep_q;
    stat_o[ST_IBRK]            = ibrk_q;
    stat_o[ST_SIG0 +: NSIG]    = sig_q;
  end

  assign irq_o      = irq_q;
  assign halt_req_o = hreq_q;
  assign halted_o   = halt_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (halt_q && !irq_q && !brk_q && !hreq_q));
  // R6
  halt_pulse_edge_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req_o |-> ($past(!halt_q) && halt_q));
  // R6
  halt_pulse_short_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req_o |=> !halt_req_o);
  // R5
  brk_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |=> brk_q);
  // R4
  brk_host_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_q) |-> $past(brk_pulse));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_v[PI_IRQ] && !clr_v[PI_IRQ]) |=> $stable(irq_o));
endmodule

// File: rtl/csr_read_port.sv
module csr_read_port #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int NWORD  = 4,
  parameter int STAT_SLOT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [NWORD];
  logic [DATA_W-1:0] rd_mux;

  for (genvar i = 0; i < NWORD; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) word_q[i] <= '0;
      else if (wr_en && (int'(sel) == i)) word_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NWORD; i++)
      if (int'(sel) == i) rd_mux = word_q[i];
    if (int'(sel) == STAT_SLOT) rd_mux = stat_i;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(sel) > STAT_SLOT) |=> (rdata_o == '0));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/csr_setclr_ctrl.sv
module csr_setclr_ctrl
  import csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int NSIG   = 8,
  localparam int NPAIR = PI_SIG0 + NSIG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_busy_i,
  input  logic              dma_full_i,
  input  logic              brk_pulse_i,
  output logic              irq_o,
  output logic              halt_req_o,
  output logic              halted_o
);
  logic              stat_wr;
  logic [NPAIR-1:0]  set_v, clr_v;
  logic              brk_clr;
  logic [DATA_W-1:0] stat_w;

  assign stat_wr = wr_en && (int'(sel) == SLOT_STAT);

  csr_cmd_decode #(.DATA_W(DATA_W), .NPAIR(NPAIR)) u_dec (
    .stat_wr   (stat_wr),
    .cmd       (wdata),
    .set_o     (set_v),
    .clr_o     (clr_v),
    .brk_clr_o (brk_clr)
  );

  csr_flag_bank #(.DATA_W(DATA_W), .NSIG(NSIG)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_v      (set_v),
    .clr_v      (clr_v),
    .brk_clr    (brk_clr),
    .brk_pulse  (brk_pulse_i),
    .dma_busy   (dma_busy_i),
    .dma_full   (dma_full_i),
    .irq_o      (irq_o),
    .halt_req_o (halt_req_o),
    .halted_o   (halted_o),
    .stat_o     (stat_w)
  );

  csr_read_port #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NWORD(SLOT_STAT), .STAT_SLOT(SLOT_STAT)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sel     (sel),
    .wdata   (wdata),
    .stat_i  (stat_w),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/csr_setclr_ctrl_test.sv
module csr_setclr_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        dma_busy_i = 0, dma_full_i = 0, brk_pulse_i = 0;
  logic        irq_o, halt_req_o, halted_o;

  int total = 0, bad = 0, mon_total = 0, mon_bad = 0;
  logic rd_seen = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_setclr_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
    .rdata_o(rdata_o), .dma_busy_i(dma_busy_i), .dma_full_i(dma_full_i),
    .brk_pulse_i(brk_pulse_i), .irq_o(irq_o), .halt_req_o(halt_req_o), .halted_o(halted_o)
  );

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= rd_en && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      mon_total++;
      if (rdata_o !== e) begin
        mon_bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata_o, e);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] e, input string req);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(req);
    rd_en = 1; sel = s;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d, input logic brk);
    @(negedge clk);
    wr_en = 1; sel = s; wdata = d; brk_pulse_i = brk;
    @(negedge clk);
    wr_en = 0; brk_pulse_i = 0;
  endtask

  task automatic pulse_brk();
    @(negedge clk);
    brk_pulse_i = 1;
    @(negedge clk);
    brk_pulse_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  function automatic logic [31:0] sig_set(input int k); return 32'h1 << (10 + 2*k); endfunction
  function automatic logic [31:0] sig_clr(input int k); return 32'h1 << (9 + 2*k); endfunction

  localparam logic [2:0] ST = 3'd4;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 halt_req", halt_req_o, 0);
    chk("R1 halted", halted_o, 1);
    rd(ST, 32'h1, "R1 status");

    // R2 clear-only halt
    wr(ST, 32'h1, 0);
    chk("R6 no pulse on clear", halt_req_o, 0);
    rd(ST, 32'h0, "R2 halt cleared");

    // R6 set halt while running
    wr(ST, 32'h2, 0);
    chk("R6 pulse", halt_req_o, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", halt_req_o, 0);
    chk("R2 halted level", halted_o, 1);
    rd(ST, 32'h1, "R2 halt set");

    // R6 set halt while halted: no pulse
    wr(ST, 32'h2, 0);
    chk("R6 no pulse when halted", halt_req_o, 0);

    // R3 both bits
    wr(ST, 32'h3, 0);
    rd(ST, 32'h1, "R3 both keeps halt=1");
    wr(ST, 32'h1, 0);
    wr(ST, 32'h3, 0);
    rd(ST, 32'h0, "R3 both keeps halt=0");

    // R2/R8 several sets
    wr(ST, (32'h1 << 6) | (32'h1 << 8) | sig_set(0) | sig_set(7), 0);
    rd(ST, 32'h40E0, "R8 layout sstep ibrk sig0 sig7");
    wr(ST, 32'h0, 0);
    rd(ST, 32'h40E0, "R3 empty command");
    wr(ST, sig_clr(0) | sig_clr(7) | sig_set(7) | (32'h1 << 5), 0);
    rd(ST, 32'h4040, "R2 clears, R3 sig7 pair");
    wr(ST, sig_set(3), 0);
    rd(ST, 32'h4440, "R2 sig3 set");

    // R4 break
    wr(ST, 32'hFFFF_FFFB, 0);
    rd(ST, 32'h4440, "R4 host cannot set break (R3 all pairs)");
    pulse_brk();
    rd(ST, 32'h4442, "R4 pulse sets break");
    wr(ST, 32'h4, 0);
    rd(ST, 32'h4440, "R4 clear break");
    wr(ST, 32'h4, 1);
    rd(ST, 32'h4442, "R5 set wins over clear");
    wr(ST, 32'h4, 0);

    // R7 interrupt line
    wr(ST, 32'h10, 0);
    chk("R7 irq set", irq_o, 1);
    rd(ST, 32'h4440, "R7 irq not in status");
    wr(ST, 32'h18, 0);
    chk("R3 irq both", irq_o, 1);
    wr(ST, 32'h8, 0);
    chk("R7 irq clear", irq_o, 0);

    // R8 pass-through levels
    dma_busy_i = 1; dma_full_i = 1;
    rd(ST, 32'h444C, "R8 busy full");

    // R9 data slots
    wr(3'd0, 32'h1234_5678, 0);
    wr(3'd1, 32'hDEAD_BEE8, 0);
    wr(3'd2, 32'h00FF_0FF8, 0);
    wr(3'd3, 32'h0123_4567, 0);
    rd(3'd0, 32'h1234_5678, "R9 slot0");
    rd(3'd1, 32'hDEAD_BEE8, "R9 slot1");
    rd(3'd2, 32'h00FF_0FF8, "R9 slot2");
    rd(3'd3, 32'h0123_4567, "R9 slot3");
    rd(3'd5, 32'h0, "R9 slot5");
    rd(3'd6, 32'h0, "R9 slot6");
    rd(3'd7, 32'h0, "R9 slot7");
    rd(ST, 32'h444C, "R9 flags untouched");
    chk("R9 irq untouched", irq_o, 0);

    // R10 hold and same-cycle read/write
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", rdata_o, 32'h444C);
    @(negedge clk);
    exp_q.push_back(32'h1234_5678);
    tag_q.push_back("R10 read before write");
    rd_en = 1; wr_en = 1; sel = 3'd0; wdata = 32'hAAAA_5555;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    rd(3'd0, 32'hAAAA_5555, "R10 write landed");

    // R1 second reset
    dma_busy_i = 0; dma_full_i = 0;
    wr(ST, 32'h10, 0);
    do_reset();
    chk("R1 irq after reset", irq_o, 0);
    rd(ST, 32'h1, "R1 status after reset");
    rd(3'd1, 32'h0, "R1 slot cleared");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end
endmodule